// File: doc/BRIEF.md
# Uncached Memory Request Adapter

This block turns a processor's memory request for a non-cacheable address into exactly one single-beat AXI-Lite transaction. The processor side offers an address, a read/write flag, write data with byte strobes and a request valid/ready pair. Read results come back on a separate return handshake: the adapter raises a read-valid flag with the data and keeps both steady until the processor acknowledges them.

Writes are non-blocking from the processor's point of view. A write is taken in the same cycle it is offered, provided the adapter is idle. The address and data phases then run on the bus without the processor waiting. The adapter only accepts a new request once the bus has returned the write response.

Only one transaction is in flight at a time. Any request offered while the adapter is busy is ignored until the ready flag returns.

Top module: `uncb_top`

## Requirements
- R1: A synchronous active-high `rst` puts the adapter into idle. The first cycle after reset shows `cpu_req_ready`=1, and `arvalid`, `rready`, `awvalid`, `wvalid`, `bready` and `cpu_rvalid` are all 0.
- R2: `cpu_req_ready` is 1 exactly when the adapter is idle. A request is taken only at a clock edge where `cpu_req_valid` and `cpu_req_ready` are both 1. A request offered while busy has no effect.
- R3: A taken request with `cpu_wr`=0 raises `arvalid` in the next cycle, with `araddr` equal to the captured address. `arvalid` stays high until an edge where `arready`=1.
- R4: After the address handshake, `rready` is 1 until an edge with `rvalid`=1. At that edge, `rdata` is captured.
- R5: From the cycle after the read-data handshake, `cpu_rvalid` is 1 and `cpu_rdata` holds the captured word. Both stay put until an edge with `cpu_rack`=1, and the adapter is idle in the following cycle. `cpu_rack` has no effect at any other time.
- R6: A taken request with `cpu_wr`=1 raises `awvalid` and `wvalid` together in the next cycle. They carry the captured address on `awaddr`, the data on `wdata` and the strobes on `wstrb`, where bit i of `wstrb` enables byte lane i (bits 8i+7..8i).
- R7: `awvalid` and `wvalid` each drop after their own handshake, independently of each other. `bready` rises in the cycle after both handshakes have happened.
- R8: A write finishes at the edge where `bvalid` and `bready` are both 1, and the adapter is idle in the next cycle. A write never raises `cpu_rvalid`.
- R9: Changes on `cpu_addr`, `cpu_wdata`, `cpu_wstrb` and `cpu_wr` after a request is taken do not alter the values presented on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor offers a request |
| cpu_req_ready | output | 1 | Adapter idle and able to take a request |
| cpu_wr | input | 1 | 1 = write request, 0 = read request |
| cpu_addr | input | 32 | Request address |
| cpu_wdata | input | 32 | Write data |
| cpu_wstrb | input | 4 | Write byte enables, bit i for byte lane i |
| cpu_rdata | output | 32 | Read result, meaningful while cpu_rvalid is 1 |
| cpu_rvalid | output | 1 | Read result available |
| cpu_rack | input | 1 | Processor acknowledges the read result |
| araddr | output | 32 | Read address channel address |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data channel data |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| awaddr | output | 32 | Write address channel address |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data channel data |
| wstrb | output | 4 | Write data channel byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
The bench varies the slave's ready timing freely, so the address and data channel handshakes of a write arrive in either order or in the same cycle. A design that waited for both ready flags together, or that kept a valid raised after its own handshake, would miscount or duplicate a beat and diverge from the model.

Requests and acknowledges are also thrown in while the adapter is busy. Request fields are scrambled every cycle after a request is taken. These catch a design that takes a second request, frees the read result early, or presents live inputs instead of captured ones.

Resets land in the middle of transactions, to catch state that survives a reset.

// File: rtl/uncb_pkg.sv
package uncb_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    localparam int unsigned STRB_W = DATA_W / 8;
    // write side tracks the address channel and the data channel
    localparam int unsigned WR_CHANS = 2;
    localparam int unsigned CH_AW = 0;
    localparam int unsigned CH_W  = 1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_AR   = 3'd1,
        PH_R    = 3'd2,
        PH_HOLD = 3'd3,
        PH_WX   = 3'd4,
        PH_B    = 3'd5
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              wr;
    } req_t;

    // a channel is finished once it has handshaken now or earlier
    function automatic logic chan_done(logic done_q, logic vld, logic rdy);
        return done_q | (vld & rdy);
    endfunction

endpackage

// File: rtl/uncb_ctrl.sv
module uncb_ctrl
    import uncb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   is_wr,
    input  logic   ar_fire,
    input  logic   r_fire,
    input  logic   rack,
    input  logic   wr_all_done,
    input  logic   b_fire,
    output phase_e phase
);
    phase_e phase_n;

    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_IDLE: if (accept)      phase_n = is_wr ? PH_WX : PH_AR;
            PH_AR:   if (ar_fire)     phase_n = PH_R;
            PH_R:    if (r_fire)      phase_n = PH_HOLD;
            PH_HOLD: if (rack)        phase_n = PH_IDLE;
            PH_WX:   if (wr_all_done) phase_n = PH_B;
            PH_B:    if (b_fire)      phase_n = PH_IDLE;
            default:                  phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_n;
    end
endmodule

// File: rtl/uncb_wr_track.sv
module uncb_wr_track
    import uncb_pkg::*;
#(
    parameter int unsigned NCH = WR_CHANS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           active,
    input  logic [NCH-1:0] rdy,
    output logic [NCH-1:0] vld,
    output logic           all_done
);
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] done_n;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign vld[c]    = active & ~done_q[c];
        assign done_n[c] = chan_done(done_q[c], vld[c], rdy[c]);

        always_ff @(posedge clk) begin
            if (rst || start) done_q[c] <= 1'b0;
            else if (active)  done_q[c] <= done_n[c];
        end
    end

    assign all_done = active & (&done_n);
endmodule

// File: rtl/uncb_capture.sv
module uncb_capture
    import uncb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  req_t              req_in,
    input  logic              r_fire,
    input  logic [DATA_W-1:0] rdata_in,
    output req_t              req_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) req_q   <= req_in;
            if (r_fire) rdata_q <= rdata_in;
        end
    end
endmodule

// File: rtl/uncb_top.sv
module uncb_top
    import uncb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [STRB_W-1:0] cpu_wstrb,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              cpu_rack,
    output logic [ADDR_W-1:0] araddr,
    output logic              arvalid,
    input  logic              arready,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rvalid,
    output logic              rready,
    output logic [ADDR_W-1:0] awaddr,
    output logic              awvalid,
    input  logic              awready,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wvalid,
    input  logic              wready,
    input  logic              bvalid,
    output logic              bready
);
    phase_e               phase;
    req_t                 req_in;
    req_t                 req_q;
    logic                 accept;
    logic                 wr_all_done;
    logic [WR_CHANS-1:0]  wr_rdy;
    logic [WR_CHANS-1:0]  wr_vld;

    assign cpu_req_ready = (phase == PH_IDLE);
    assign accept        = cpu_req_valid & cpu_req_ready;
    assign req_in        = '{addr: cpu_addr, data: cpu_wdata, strb: cpu_wstrb, wr: cpu_wr};

    assign wr_rdy[CH_AW] = awready;
    assign wr_rdy[CH_W]  = wready;

    uncb_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .is_wr       (cpu_wr),
        .ar_fire     (arvalid & arready),
        .r_fire      (rready & rvalid),
        .rack        (cpu_rack),
        .wr_all_done (wr_all_done),
        .b_fire      (bready & bvalid),
        .phase       (phase)
    );

    uncb_wr_track #(.NCH(WR_CHANS)) u_wtrk (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .active   (phase == PH_WX),
        .rdy      (wr_rdy),
        .vld      (wr_vld),
        .all_done (wr_all_done)
    );

    uncb_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_in   (req_in),
        .r_fire   (rready & rvalid),
        .rdata_in (rdata),
        .req_q    (req_q),
        .rdata_q  (cpu_rdata)
    );

    assign arvalid    = (phase == PH_AR);
    assign araddr     = req_q.addr;
    assign rready     = (phase == PH_R);
    assign cpu_rvalid = (phase == PH_HOLD);
    assign awvalid    = wr_vld[CH_AW];
    assign awaddr     = req_q.addr;
    assign wvalid     = wr_vld[CH_W];
    assign wdata      = req_q.data;
    assign wstrb      = req_q.strb;
    assign bready     = (phase == PH_B);
endmodule

// File: rtl/uncb_checks.sv
module uncb_checks
    import uncb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rvalid,
    input logic              cpu_rack,
    input logic [ADDR_W-1:0] araddr,
    input logic              arvalid,
    input logic              arready,
    input logic              rready,
    input logic [ADDR_W-1:0] awaddr,
    input logic              awvalid,
    input logic              awready,
    input logic [DATA_W-1:0] wdata,
    input logic              wvalid,
    input logic              wready,
    input logic              bvalid,
    input logic              bready
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !arvalid && !rready && !awvalid && !wvalid && !bready && !cpu_rvalid);

    p_rd_start_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_ready && !cpu_wr |=> arvalid);

    p_ar_hold_r3: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> arvalid && $stable(araddr));

    p_ret_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid && !cpu_rack |=> cpu_rvalid && $stable(cpu_rdata));

    p_ret_done_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid && cpu_rack |=> cpu_req_ready);

    p_wr_start_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_ready && cpu_wr |=> awvalid && wvalid);

    p_aw_hold_r7: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr));

    p_w_hold_r7: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready |=> wvalid && $stable(wdata));

    p_b_done_r8: assert property (@(posedge clk) disable iff (rst)
        bready && bvalid |=> cpu_req_ready);
endmodule

bind uncb_top uncb_checks chk_i (.*);

// File: tb/uncb_top_tb_top.sv
module uncb_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_CYC      = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_wr = 1'b0, cpu_rack = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, rdata = '0;
    logic [3:0]  cpu_wstrb = '0;
    logic        arready = 1'b0, rvalid = 1'b0, awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
    logic        cpu_req_ready, cpu_rvalid, arvalid, rready, awvalid, wvalid, bready;
    logic [31:0] cpu_rdata, araddr, awaddr, wdata;
    logic [3:0]  wstrb;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uncb_top dut_i (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: which transaction is outstanding and what it carries
    int          m_ph;     // 0 idle,1 addr-read,2 data-read,3 result held,4 write beats,5 response
    bit          m_aw_sent, m_w_sent;
    logic [31:0] m_addr, m_data, m_rd;
    logic [3:0]  m_strb;

    task automatic model_step();
        if (rst) begin
            m_ph = 0; m_aw_sent = 0; m_w_sent = 0;
        end else begin
            case (m_ph)
                0: if (cpu_req_valid) begin
                       m_addr = cpu_addr; m_data = cpu_wdata; m_strb = cpu_wstrb;
                       m_aw_sent = 0; m_w_sent = 0;
                       m_ph = cpu_wr ? 4 : 1;
                   end
                1: if (arready) m_ph = 2;
                2: if (rvalid) begin m_rd = rdata; m_ph = 3; end
                3: if (cpu_rack) m_ph = 0;
                4: begin
                       if (awready) m_aw_sent = 1;
                       if (wready)  m_w_sent = 1;
                       if (m_aw_sent && m_w_sent) m_ph = 5;
                   end
                5: if (bvalid) m_ph = 0;
                default: m_ph = 0;
            endcase
        end
    endtask

    task automatic compare();
        chk("R2", "cpu_req_ready", 32'(cpu_req_ready), 32'(m_ph == 0));
        chk("R3", "arvalid", 32'(arvalid), 32'(m_ph == 1));
        chk("R4", "rready", 32'(rready), 32'(m_ph == 2));
        chk("R5", "cpu_rvalid", 32'(cpu_rvalid), 32'(m_ph == 3));
        chk("R6", "awvalid", 32'(awvalid), 32'(m_ph == 4 && !m_aw_sent));
        chk("R7", "wvalid", 32'(wvalid), 32'(m_ph == 4 && !m_w_sent));
        chk("R8", "bready", 32'(bready), 32'(m_ph == 5));
        if (m_ph == 1) chk("R9", "araddr", araddr, m_addr);
        if (m_ph == 3) chk("R5", "cpu_rdata", cpu_rdata, m_rd);
        if (m_ph == 4) begin
            chk("R9", "awaddr", awaddr, m_addr);
            chk("R6", "wdata", wdata, m_data);
            chk("R6", "wstrb", 32'(wstrb), 32'(m_strb));
        end
    endtask

    task automatic check_idle_r1();
        chk("R1", "ready after reset", 32'(cpu_req_ready), 32'd1);
        chk("R1", "valids after reset",
            {26'd0, arvalid, rready, awvalid, wvalid, bready, cpu_rvalid}, 32'd0);
    endtask

    initial begin
        process::self().srandom(32'h5eed);
        for (int cyc = 0; cyc < N_CYC; cyc++) begin
            bit was_rst;
            @(negedge clk);
            was_rst = rst;
            model_step();
            compare();
            if (was_rst) check_idle_r1();
            // resets at start and in the middle of traffic
            rst = (cyc < 3) || (cyc >= 2500 && cyc < 2502) || (cyc >= 4700 && cyc < 4701);
            cpu_req_valid = ($urandom_range(0, 99) < 50);
            cpu_wr    = $urandom_range(0, 1);
            cpu_addr  = $urandom;
            cpu_wdata = $urandom;
            cpu_wstrb = 4'($urandom);
            cpu_rack  = ($urandom_range(0, 99) < 40);
            // slow or fast slave phases
            if (cyc < 3000) begin
                arready = ($urandom_range(0, 99) < 50);
                awready = ($urandom_range(0, 99) < 50);
                wready  = ($urandom_range(0, 99) < 50);
            end else begin
                arready = ($urandom_range(0, 99) < 85);
                awready = ($urandom_range(0, 99) < 20);
                wready  = ($urandom_range(0, 99) < 85);
            end
            rdata  = $urandom;
            rvalid = (m_ph == 2) && ($urandom_range(0, 99) < 60);
            bvalid = (m_ph == 5) && ($urandom_range(0, 99) < 60);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * (N_CYC + 1000));
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule